// File: doc/BRIEF.md
# Burst Beat Address Sequencer

This block turns a single burst descriptor into the address of every beat of that burst. The descriptor gives a start address, a beat count, a beat-size code and a burst kind. A load strobe captures it while the sequencer is idle. From the next cycle the block shows the address of the current beat and a flag that marks the final beat. Each cycle in which the consumer accepts a beat moves the sequencer to the next beat. After the final beat it goes back to idle.

Three address patterns are supported. The first keeps one address for the whole burst. The second steps upward by the beat size and aligns the address after an unaligned first beat. The third steps upward inside a window whose size is a power of two and folds back to the bottom of that window. A descriptor the block cannot follow is rejected with an error flag and produces no beats. An incrementing burst that runs past a 4096-byte page is still sequenced, but it raises a page-crossing flag. The block is meant to sit behind the address channel of a memory-mapped slave or beside a DMA engine that needs per-beat addresses.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is held and after it is released, busy_o, last_o, err_o, page_cross_o and addr_o are all zero.
- R2: A load_i pulse while busy_o is low captures the descriptor. beats_m1_i holds the beat count minus one (0..255 gives 1..256 beats). size_i is log2 of the bytes per beat (0 = 1 byte, 7 = 128 bytes). kind_i is 00 for fixed, 01 for incrementing and 10 for wrapping. For a legal descriptor, busy_o is high and addr_o equals start_i in the next cycle.
- R3: Fixed kind: addr_o holds the start address for every beat.
- R4: Incrementing kind with an aligned start: each beat address is the previous one plus 2^size_i, modulo 2^ADDR_W.
- R5: Incrementing kind with an unaligned start: beat 0 uses start_i. Beat i > 0 uses start_i rounded down to 2^size_i, plus i times 2^size_i.
- R6: Wrapping kind: the window base is start_i rounded down to 2^size_i times the beat count. The address steps up by 2^size_i. When it would reach base plus the window size, it returns to the base, so a start above the base still touches every slot exactly once.
- R7: A wrapping descriptor whose beat count is not 2, 4, 8 or 16, or whose start_i is not a multiple of 2^size_i, sets err_o in the next cycle and leaves busy_o low.
- R8: kind_i = 11 is reserved. It sets err_o in the next cycle and leaves busy_o low.
- R9: last_o is high exactly while the beat with index beats_m1 is shown. Accepting that beat (advance_i high) makes busy_o low in the next cycle. advance_i while idle changes nothing.
- R10: While busy_o is high and advance_i is low, addr_o and last_o hold their values.
- R11: load_i while busy_o is high is ignored. This includes the cycle in which the final beat is accepted: the burst, err_o and page_cross_o are unaffected.
- R12: For the incrementing kind, page_cross_o is set in the cycle after the load when the last byte of the burst (the aligned start plus beat count times beat size, minus one) lies in a different 4096-byte page than start_i. The beats are still generated. It is zero for the other kinds. err_o and page_cross_o keep their values until the next accepted load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture the descriptor when idle |
| start_i | input | ADDR_W | Start address of the burst |
| beats_m1_i | input | LEN_W | Beat count minus one |
| size_i | input | 3 | log2 of bytes per beat |
| kind_i | input | 2 | Burst kind code |
| advance_i | input | 1 | Current beat accepted this cycle |
| busy_o | output | 1 | A burst is being sequenced |
| addr_o | output | ADDR_W | Address of the current beat |
| last_o | output | 1 | Current beat is the final one |
| err_o | output | 1 | Last load was rejected as illegal |
| page_cross_o | output | 1 | Last accepted incrementing burst crosses a 4 KB page |

## Verification
Two things can happen in the same cycle: a new load request and the acceptance of the final beat of the running burst. Because busy_o is still high in that cycle, the load must be dropped. The bench provokes this by raising load_i with a reserved-kind descriptor in the same cycle that advance_i accepts the last beat. It also injects such loads at random during bursts. A correct block then shows busy_o and err_o low in the following cycle, and the address sequence runs on unchanged. If the load were wrongly taken, err_o would rise.

// File: rtl/bag_pkg.sv
package bag_pkg;

   typedef enum logic [1:0] {
      BK_FIXED = 2'b00,
      BK_INCR  = 2'b01,
      BK_WRAP  = 2'b10,
      BK_RSVD  = 2'b11
   } burst_kind_e;

   localparam int unsigned SIZE_CODE_W = 3;
   localparam int unsigned KIND_W      = 2;

endpackage

// File: rtl/bag_decode.sv
// Descriptor checks: beat size, masks, wrap window and page crossing.
module bag_decode
   import bag_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned LEN_W       = 8,
   parameter int unsigned PAGE_W      = 12,
   parameter bit          CROSS_CHECK = 1'b1
) (
   input  logic [ADDR_W-1:0]      start_i,
   input  logic [LEN_W-1:0]       beats_m1_i,
   input  logic [SIZE_CODE_W-1:0] size_i,
   input  burst_kind_e            kind_i,
   output logic [ADDR_W-1:0]      align_mask_o,
   output logic [ADDR_W-1:0]      wrap_mask_o,
   output logic [ADDR_W-1:0]      wrap_base_o,
   output logic                   illegal_o,
   output logic                   crosses_o
);

   localparam logic [ADDR_W-1:0] ONE_A = {{(ADDR_W-1){1'b0}}, 1'b1};

   logic [ADDR_W-1:0] bytes_w;
   logic [ADDR_W-1:0] beats_w;
   logic [ADDR_W-1:0] total_w;
   logic              len_pow2_ok;
   logic              misaligned;

   always_comb begin
      bytes_w      = ONE_A << size_i;
      beats_w      = ADDR_W'(beats_m1_i) + ONE_A;
      total_w      = bytes_w * beats_w;
      align_mask_o = bytes_w - ONE_A;
      wrap_mask_o  = total_w - ONE_A;
      wrap_base_o  = start_i & ~wrap_mask_o;
      misaligned   = (start_i & align_mask_o) != '0;
      len_pow2_ok  = (beats_m1_i == LEN_W'(1)) || (beats_m1_i == LEN_W'(3)) ||
                     (beats_m1_i == LEN_W'(7)) || (beats_m1_i == LEN_W'(15));
      unique case (kind_i)
         BK_FIXED: illegal_o = 1'b0;
         BK_INCR:  illegal_o = 1'b0;
         BK_WRAP:  illegal_o = misaligned || !len_pow2_ok;
         default:  illegal_o = 1'b1;
      endcase
   end

   generate
      if (CROSS_CHECK) begin : g_cross
         logic [ADDR_W:0] last_byte;
         always_comb begin
            last_byte = {1'b0, start_i & ~align_mask_o} + {1'b0, total_w} - {{ADDR_W{1'b0}}, 1'b1};
            crosses_o = (kind_i == BK_INCR) &&
                        (last_byte[ADDR_W:PAGE_W] != {1'b0, start_i[ADDR_W-1:PAGE_W]});
         end
      end else begin : g_no_cross
         assign crosses_o = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/bag_step.sv
// Next-beat address for each burst kind.
module bag_step
   import bag_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  burst_kind_e       kind_i,
   input  logic [ADDR_W-1:0] align_mask_i,
   input  logic [ADDR_W-1:0] wrap_mask_i,
   output logic [ADDR_W-1:0] next_o
);

   logic [ADDR_W-1:0] aligned;
   logic [ADDR_W-1:0] bumped;

   always_comb begin
      aligned = addr_i & ~align_mask_i;
      bumped  = aligned + align_mask_i + {{(ADDR_W-1){1'b0}}, 1'b1};
      unique case (kind_i)
         BK_INCR: next_o = bumped;
         BK_WRAP: next_o = (addr_i & ~wrap_mask_i) | (bumped & wrap_mask_i);
         default: next_o = addr_i;
      endcase
   end

endmodule

// File: rtl/bag_beat_ctr.sv
// Beat counter and busy state.
module bag_beat_ctr #(
   parameter int unsigned LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             step_i,
   input  logic [LEN_W-1:0] beats_m1_i,
   output logic             busy_o,
   output logic             last_o
);

   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] len_q;
   logic             busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         len_q  <= '0;
      end else if (start_i && !busy_q) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
         len_q  <= beats_m1_i;
      end else if (step_i && busy_q) begin
         if (cnt_q == len_q) begin
            busy_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign busy_o = busy_q;
   assign last_o = busy_q && (cnt_q == len_q);

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (cnt_q <= len_q)); // R9

   AST_LAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && step_i) |=> !busy_o); // R9

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import bag_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned LEN_W       = 8,
   parameter int unsigned PAGE_W      = 12,
   parameter bit          CROSS_CHECK = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load_i,
   input  logic [ADDR_W-1:0]      start_i,
   input  logic [LEN_W-1:0]       beats_m1_i,
   input  logic [SIZE_CODE_W-1:0] size_i,
   input  logic [KIND_W-1:0]      kind_i,
   input  logic                   advance_i,
   output logic                   busy_o,
   output logic [ADDR_W-1:0]      addr_o,
   output logic                   last_o,
   output logic                   err_o,
   output logic                   page_cross_o
);

   localparam int unsigned MAX_TOTAL_W = 8 + LEN_W;

   generate
      if (LEN_W < 4 || LEN_W > 8) begin : g_bad_len
         $error("LEN_W must lie in 4..8");
      end
      if (ADDR_W < MAX_TOTAL_W || ADDR_W <= PAGE_W) begin : g_bad_addr
         $error("ADDR_W too narrow for the largest burst or page");
      end
   endgenerate

   burst_kind_e       kind_in;
   burst_kind_e       kind_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] align_q;
   logic [ADDR_W-1:0] wmask_q;
   logic [ADDR_W-1:0] wbase_q;
   logic              err_q;
   logic              cross_q;

   logic [ADDR_W-1:0] dec_align;
   logic [ADDR_W-1:0] dec_wmask;
   logic [ADDR_W-1:0] dec_wbase;
   logic              dec_illegal;
   logic              dec_cross;
   logic [ADDR_W-1:0] next_addr;
   logic              accept;
   logic              start_ok;
   logic              busy;
   logic              last;

   assign kind_in = burst_kind_e'(kind_i);

   bag_decode #(
      .ADDR_W      (ADDR_W),
      .LEN_W       (LEN_W),
      .PAGE_W      (PAGE_W),
      .CROSS_CHECK (CROSS_CHECK)
   ) u_decode (
      .start_i      (start_i),
      .beats_m1_i   (beats_m1_i),
      .size_i       (size_i),
      .kind_i       (kind_in),
      .align_mask_o (dec_align),
      .wrap_mask_o  (dec_wmask),
      .wrap_base_o  (dec_wbase),
      .illegal_o    (dec_illegal),
      .crosses_o    (dec_cross)
   );

   bag_step #(
      .ADDR_W (ADDR_W)
   ) u_step (
      .addr_i       (addr_q),
      .kind_i       (kind_q),
      .align_mask_i (align_q),
      .wrap_mask_i  (wmask_q),
      .next_o       (next_addr)
   );

   assign accept   = load_i && !busy;
   assign start_ok = accept && !dec_illegal;

   bag_beat_ctr #(
      .LEN_W (LEN_W)
   ) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_ok),
      .step_i     (advance_i),
      .beats_m1_i (beats_m1_i),
      .busy_o     (busy),
      .last_o     (last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         kind_q  <= BK_FIXED;
         align_q <= '0;
         wmask_q <= '0;
         wbase_q <= '0;
         err_q   <= 1'b0;
         cross_q <= 1'b0;
      end else if (accept) begin
         err_q   <= dec_illegal;
         cross_q <= !dec_illegal && dec_cross;
         if (!dec_illegal) begin
            addr_q  <= start_i;
            kind_q  <= kind_in;
            align_q <= dec_align;
            wmask_q <= dec_wmask;
            wbase_q <= dec_wbase;
         end
      end else if (busy && advance_i && !last) begin
         addr_q <= next_addr;
      end
   end

   assign busy_o       = busy;
   assign addr_o       = addr_q;
   assign last_o       = last;
   assign err_o        = err_q;
   assign page_cross_o = cross_q;

   AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && advance_i && !last_o && kind_q == BK_FIXED) |=> $stable(addr_o)); // R3

   AST_INCR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && advance_i && !last_o && kind_q == BK_INCR) |=> ((addr_o & align_q) == '0)); // R5

   AST_WRAP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && kind_q == BK_WRAP) |-> ((addr_o & ~wmask_q) == wbase_q)); // R6

   AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !busy_o); // R7

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !advance_i) |=> ($stable(addr_o) && $stable(last_o))); // R10

   AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && load_i) |=> ($stable(err_o) && $stable(page_cross_o))); // R11

endmodule

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;

   localparam int unsigned AW = 32;
   localparam int unsigned LW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load_i = 1'b0;
   logic [AW-1:0] start_i = '0;
   logic [LW-1:0] beats_m1_i = '0;
   logic [2:0]    size_i = '0;
   logic [1:0]    kind_i = '0;
   logic          advance_i = 1'b0;
   logic          busy_o;
   logic [AW-1:0] addr_o;
   logic          last_o;
   logic          err_o;
   logic          page_cross_o;

   int unsigned n_chk = 0;
   int unsigned n_bad = 0;
   int unsigned cycles = 0;

   always #10 clk = ~clk;

   burst_addr_gen u0 (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_i(start_i),
      .beats_m1_i(beats_m1_i), .size_i(size_i), .kind_i(kind_i),
      .advance_i(advance_i), .busy_o(busy_o), .addr_o(addr_o),
      .last_o(last_o), .err_o(err_o), .page_cross_o(page_cross_o)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_addr(input logic [31:0] st, input int len_m1,
                                            input int sz, input int kd, input int i);
      longint bytes = longint'(1) << sz;
      longint tot   = bytes * (len_m1 + 1);
      longint s     = longint'(st);
      longint base;
      if (kd == 0) return st;
      if (kd == 1) begin
         if (i == 0) return st;
         return 32'((s - (s % bytes)) + longint'(i) * bytes);
      end
      base = s - (s % tot);
      return 32'(base + ((s - base) + longint'(i) * bytes) % tot);
   endfunction

   function automatic bit ref_illegal(input logic [31:0] st, input int len_m1,
                                      input int sz, input int kd);
      longint bytes = longint'(1) << sz;
      if (kd == 3) return 1'b1;
      if (kd == 2)
         return !(len_m1 == 1 || len_m1 == 3 || len_m1 == 7 || len_m1 == 15) ||
                ((longint'(st) % bytes) != 0);
      return 1'b0;
   endfunction

   function automatic bit ref_cross(input logic [31:0] st, input int len_m1,
                                    input int sz, input int kd);
      longint bytes = longint'(1) << sz;
      longint s     = longint'(st);
      longint lastb = (s - (s % bytes)) + bytes * (len_m1 + 1) - 1;
      if (kd != 1) return 1'b0;
      return (lastb / 4096) != (s / 4096);
   endfunction

   // stall: 0 = accept every beat, 1 = random stalls; poke: random junk loads while busy
   task automatic run_burst(input logic [31:0] st, input int len_m1, input int sz,
                            input int kd, input bit stall, input bit poke, input bit clash);
      bit ill = ref_illegal(st, len_m1, sz, kd);
      bit crs = ref_cross(st, len_m1, sz, kd);
      int i;
      logic [31:0] held;
      @(negedge clk);
      load_i = 1'b1; start_i = st; beats_m1_i = LW'(len_m1);
      size_i = 3'(sz); kind_i = 2'(kd); advance_i = 1'b0;
      @(negedge clk);
      load_i = 1'b0;
      check(busy_o == !ill, "R2 busy after load", longint'(busy_o), longint'(!ill));
      check(err_o == ill, (kd == 3) ? "R8 err" : "R7 err", longint'(err_o), longint'(ill));
      check(page_cross_o == crs, "R12 page cross", longint'(page_cross_o), longint'(crs));
      if (ill) begin
         @(negedge clk);
         check(busy_o == 1'b0, "R7 stays idle", longint'(busy_o), 0);
         return;
      end
      i = 0;
      while (i <= len_m1) begin
         bit adv = stall ? (($urandom % 3) != 0) : 1'b1;
         bit jl  = poke && (($urandom % 5) == 0);
         if (clash && i == len_m1) begin adv = 1'b1; jl = 1'b1; end
         check(addr_o == ref_addr(st, len_m1, sz, kd, i),
               (kd == 0) ? "R3 addr" : (kd == 2) ? "R6 addr" :
               ((st % (32'd1 << sz)) != 0) ? "R5 addr" : "R4 addr",
               longint'(addr_o), longint'(ref_addr(st, len_m1, sz, kd, i)));
         check(last_o == (i == len_m1), "R9 last", longint'(last_o), longint'(i == len_m1));
         check(busy_o == 1'b1, "R10 busy during burst", longint'(busy_o), 1);
         advance_i = adv;
         load_i = jl;
         if (jl) begin kind_i = 2'b11; start_i = ~st; end
         @(negedge clk);
         load_i = 1'b0;
         if (adv) i++;
      end
      advance_i = 1'b0;
      check(busy_o == 1'b0, "R9 idle after last", longint'(busy_o), 0);
      check(last_o == 1'b0, "R9 last low when idle", longint'(last_o), 0);
      check(err_o == 1'b0, "R11 busy load ignored", longint'(err_o), 0);
      check(page_cross_o == crs, "R12 flag held", longint'(page_cross_o), longint'(crs));
      held = addr_o;
      advance_i = 1'b1;
      @(negedge clk);
      advance_i = 1'b0;
      check(busy_o == 1'b0 && addr_o == held, "R9 idle advance", longint'(addr_o), longint'(held));
   endtask

   initial begin
      void'($urandom(32'd7741));
      #5;
      check(busy_o == 0 && last_o == 0 && err_o == 0 && page_cross_o == 0 && addr_o == 0,
            "R1 reset", longint'(addr_o), 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy_o == 0 && last_o == 0 && err_o == 0 && page_cross_o == 0 && addr_o == 0,
            "R1 after release", longint'({busy_o, last_o, err_o, page_cross_o}), 0);

      run_burst(32'h0000_1234, 3, 2, 0, 1'b0, 1'b0, 1'b0);   // R3
      run_burst(32'h0000_2000, 7, 3, 1, 1'b1, 1'b0, 1'b0);   // R4
      run_burst(32'h0000_1003, 4, 2, 1, 1'b0, 1'b0, 1'b0);   // R5
      run_burst(32'h0000_0038, 3, 2, 2, 1'b0, 1'b0, 1'b0);   // R6 38,3C,30,34
      run_burst(32'h0000_4580, 15, 7, 2, 1'b1, 1'b0, 1'b0);  // R6 large window
      run_burst(32'h0000_0040, 4, 2, 2, 1'b0, 1'b0, 1'b0);   // R7 bad count
      run_burst(32'h0000_0042, 3, 2, 2, 1'b0, 1'b0, 1'b0);   // R7 misaligned
      run_burst(32'h0000_0100, 3, 2, 3, 1'b0, 1'b0, 1'b0);   // R8 reserved
      run_burst(32'h0000_0FF0, 7, 2, 1, 1'b0, 1'b0, 1'b0);   // R12 crosses
      run_burst(32'h0000_0FE0, 7, 2, 1, 1'b0, 1'b0, 1'b0);   // R12 fits
      run_burst(32'hFFFF_FFFC, 2, 2, 1, 1'b0, 1'b0, 1'b0);   // R4 address rollover
      run_burst(32'h0000_8000, 255, 0, 1, 1'b0, 1'b0, 1'b0); // R9 256 beats
      run_burst(32'h0000_0500, 5, 1, 1, 1'b1, 1'b1, 1'b1);   // R11 load on final accept

      for (int n = 0; n < 250; n++) begin
         int kd = $urandom % 8;
         int sz = $urandom % 8;
         int ln;
         logic [31:0] st = $urandom;
         kd = (kd < 3) ? kd : (kd < 7) ? 2 : 3;
         if (kd == 2) begin
            ln = (($urandom % 10) == 0) ? ($urandom % 20) : ((2 << ($urandom % 4)) - 1);
            if (($urandom % 6) != 0) st = st & ~((32'd1 << sz) - 1);
         end else begin
            ln = (($urandom % 20) == 0) ? 255 : ($urandom % 24);
         end
         run_burst(st, ln, sz, kd, 1'b1, 1'b1, ($urandom % 4) == 0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule